// File: doc/BRIEF.md
# Triple Watchdog Timer

This peripheral contains three independent 16-bit watchdog channels on a small synchronous register bus. Software writes a channel's limit register, and that write starts a countdown from the written value. A tick-enable input decrements each running counter once per pulse. In a full system the tick arrives every 100 ms, so a limit is a count of tenths of a second. To keep a channel alive, software reads the channel's counter register. That read returns the current count and reloads the counter from the limit.

When a channel's count runs out, the channel stops and sets its expired flag, and it then takes the action assigned to it:
- Channel 0 raises a level interrupt.
- Channel 1 emits a one-cycle CPU reset pulse.
- Channel 2 emits a one-cycle full system reset pulse.

A shared mask byte can suppress any channel's action. The channel still counts and still expires while its action is masked.

The bus accepts one access per cycle, with no wait states and no back-pressure. Read data is registered and appears in the cycle after the request. Halfword registers travel across the bus byte-swapped. Byte data uses bus lane [7:0].

Top module: `wdt_triple`

## Requirements
- R1: After reset, every channel's counter and limit hold the value 1 (a halfword read returns 16'h0100), every status byte and the mask byte read 0, and irq, cpu_rst_pulse and sys_rst_pulse are low.
- R2: Halfword transfers are byte-swapped. A logical register value V appears on bus_rdata as {V[7:0],V[15:8]}. A halfword write of bus word W stores {W[7:0],W[15:8]}.
- R3: A halfword write to a channel's limit register (channel n base 0x10*n, offset +0x4) stores the limit, loads the counter with it, sets running and clears expired. A read of the limit register has no side effect.
- R4: A running channel decrements its counter by one on each cycle with tick high. Without a tick, or while the channel is not running, the counter holds its value.
- R5: A halfword read of a running channel's counter (offset +0x0) returns the current count and then reloads the counter from the limit. The same read on a channel that is not running leaves the counter unchanged.
- R6: A tick that arrives while a running counter is at 1 or 0 sets the counter to 0, clears running and sets expired. The channel stays in that state, whatever ticks or counter reads follow, until its limit is written again. This includes a limit of 0, which expires on the next tick.
- R7: In the cycle after the expiring tick, channel 1 drives cpu_rst_pulse high for exactly one cycle and channel 2 drives sys_rst_pulse high for exactly one cycle. irq stays high while channel 0 is expired and unmasked.
- R8: The mask byte at 0x30 holds one bit per channel in bits 2:0, and bits 7:3 read as 0. A 1 in bit n suppresses channel n's action, but the channel still expires and its status still shows it.
- R9: A channel's status byte (offset +0x8) has bit 0 for running and bit 1 for expired, and bits 7:2 read as 0.
- R10: An access of the wrong width is ignored and has no side effect: a byte access to a counter or limit register, or a halfword access to a status or mask byte. A write changes nothing, a read returns 0, and no kick happens.
- R11: When a counter read and a tick reach the same channel in the same cycle, the reload wins and the tick is dropped for that channel.
- R12: The byte at 0x34 and every undecoded address read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable (one 100 ms period in a system) |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_hw | input | 1 | 1 = halfword, 0 = byte access |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 16 | Write data (byte data in [7:0]) |
| bus_rdata | output | 16 | Read data, valid the cycle after a read request |
| irq | output | 1 | Channel 0 expiry interrupt (level) |
| cpu_rst_pulse | output | 1 | Channel 1 expiry, one-cycle CPU reset |
| sys_rst_pulse | output | 1 | Channel 2 expiry, one-cycle system reset |

## Verification
The bench drives a tick in the same cycle as a counter read. A design that let the tick through would report a count one below the limit.

It reads the counter of an expired channel twice. A design that reloaded on that read would bring a dead channel back to life. It also uses a limit of 0, which must expire on the very next tick rather than wrap to 16'hFFFF.

An asymmetric value exposes any missing byte swap. Wrong-width accesses, including a byte read placed between a tick and a halfword read, show whether a design kicks or writes through the wrong lane. Masked and unmasked expiries of the pulse channels show whether a design gates the status flag along with the action, or lets a pulse last longer than one cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int HW_W   = 16;
  localparam int ADDR_W = 6;
  localparam int N_CH   = 3;
  localparam int WIN_W  = 2;
  localparam int MASK_WIN = N_CH;

  localparam logic [3:0] OFF_COUNT = 4'h0;
  localparam logic [3:0] OFF_LIMIT = 4'h4;
  localparam logic [3:0] OFF_STAT  = 4'h8;
  localparam logic [3:0] OFF_MASK  = 4'h0;

  function automatic logic [HW_W-1:0] swap16(input logic [HW_W-1:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/wdt_chan.sv
module wdt_chan
  import wdt_pkg::*;
#(
  parameter int          W    = HW_W,
  parameter logic [W-1:0] INIT = W'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         kick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         mask,
  output logic [W-1:0] count,
  output logic [W-1:0] limit,
  output logic         running,
  output logic         expired,
  output logic         fire
);

  logic last_step;
  assign last_step = (count <= W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= INIT;
      limit   <= INIT;
      running <= 1'b0;
      expired <= 1'b0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        limit   <= load_val;
        count   <= load_val;
        running <= 1'b1;
        expired <= 1'b0;
      end else if (kick) begin
        if (running) count <= limit;
      end else if (tick && running) begin
        if (last_step) begin
          count   <= '0;
          running <= 1'b0;
          expired <= 1'b1;
          fire    <= ~mask;
        end else begin
          count <= count - W'(1);
        end
      end
    end
  end

  a_r3_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (running && !expired && count == $past(load_val) && limit == $past(load_val)));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(count));

  a_r5_kick_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (running && kick && !load) |=> (count == $past(limit)));

  a_r6_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !kick && !load && count <= W'(1)) |=> (expired && !running && count == '0));

  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> (count == '0 && expired));

  a_r8_fire_masked: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($past(!mask) && expired));

endmodule

// File: rtl/wdt_regmap.sv
module wdt_regmap
  import wdt_pkg::*;
(
  input  logic                      req,
  input  logic                      we,
  input  logic                      hw,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [HW_W-1:0]           wdata,
  input  logic [N_CH-1:0][HW_W-1:0] count,
  input  logic [N_CH-1:0][HW_W-1:0] limit,
  input  logic [N_CH-1:0]           running,
  input  logic [N_CH-1:0]           expired,
  input  logic [N_CH-1:0]           mask,
  output logic [N_CH-1:0]           kick,
  output logic [N_CH-1:0]           load,
  output logic [HW_W-1:0]           load_val,
  output logic                      mask_we,
  output logic [N_CH-1:0]           mask_val,
  output logic [HW_W-1:0]           rd_data
);

  logic [WIN_W-1:0] win;
  logic [3:0]       off;

  assign win      = addr[ADDR_W-1 -: WIN_W];
  assign off      = addr[3:0];
  assign load_val = swap16(wdata);
  assign mask_val = wdata[N_CH-1:0];

  always_comb begin
    kick    = '0;
    load    = '0;
    mask_we = 1'b0;
    rd_data = '0;
    if (win == WIN_W'(MASK_WIN)) begin
      if (off == OFF_MASK && !hw) begin
        mask_we = req & we;
        rd_data = HW_W'(mask);
      end
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        if (win == WIN_W'(i)) begin
          case (off)
            OFF_COUNT: if (hw) begin
              rd_data = swap16(count[i]);
              kick[i] = req & ~we;
            end
            OFF_LIMIT: if (hw) begin
              rd_data = swap16(limit[i]);
              load[i] = req & we;
            end
            OFF_STAT: if (!hw) rd_data = HW_W'({expired[i], running[i]});
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/wdt_triple.sv
module wdt_triple
  import wdt_pkg::*;
#(
  parameter logic [HW_W-1:0] RST_VAL = HW_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_hw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HW_W-1:0]   bus_wdata,
  output logic [HW_W-1:0]   bus_rdata,
  output logic              irq,
  output logic              cpu_rst_pulse,
  output logic              sys_rst_pulse
);

  logic [N_CH-1:0][HW_W-1:0] cnt_all, lim_all;
  logic [N_CH-1:0]           run_all, exp_all, fire_all, kick_all, load_all;
  logic [N_CH-1:0]           mask_r, mask_val;
  logic [HW_W-1:0]           load_val, rd_data;
  logic                      mask_we;

  wdt_regmap u_map (
    .req(bus_req), .we(bus_we), .hw(bus_hw), .addr(bus_addr), .wdata(bus_wdata),
    .count(cnt_all), .limit(lim_all), .running(run_all), .expired(exp_all),
    .mask(mask_r), .kick(kick_all), .load(load_all), .load_val(load_val),
    .mask_we(mask_we), .mask_val(mask_val), .rd_data(rd_data)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    wdt_chan #(.W(HW_W), .INIT(RST_VAL)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .kick(kick_all[g]), .load(load_all[g]), .load_val(load_val),
      .mask(mask_r[g]), .count(cnt_all[g]), .limit(lim_all[g]),
      .running(run_all[g]), .expired(exp_all[g]), .fire(fire_all[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_r    <= '0;
      bus_rdata <= '0;
    end else begin
      if (mask_we) mask_r <= mask_val;
      if (bus_req && !bus_we) bus_rdata <= rd_data;
    end
  end

  assign irq           = exp_all[0] & ~mask_r[0];
  assign cpu_rst_pulse = fire_all[1];
  assign sys_rst_pulse = fire_all[2];

  a_r7_irq_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_all[0] |-> irq);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst_pulse || sys_rst_pulse) |=> (!$past(cpu_rst_pulse) || !cpu_rst_pulse) && (!$past(sys_rst_pulse) || !sys_rst_pulse));

  a_r10_byte_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_hw && !tick) |=> $stable(cnt_all) && $stable(lim_all));

  a_r11_kick_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_hw && bus_addr == 6'h00 && run_all[0] && tick) |=> (cnt_all[0] == $past(lim_all[0])));

endmodule

// File: tb/sim_wdt_triple.sv
module sim_wdt_triple;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_hw = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, cpu_rst_pulse, sys_rst_pulse;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wdt_triple u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_req(bus_req), .bus_we(bus_we),
    .bus_hw(bus_hw), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .cpu_rst_pulse(cpu_rst_pulse), .sys_rst_pulse(sys_rst_pulse)
  );

  // op: 0 halfword write, 1 byte write, 2 halfword read, 3 byte read, 4 tick x data
  localparam int NV = 35;
  localparam logic [44:0] TBL [NV] = '{
    {3'd2, 6'h00, 16'h0000, 16'h0100, 4'd1},  // R1 counter reset value
    {3'd2, 6'h04, 16'h0000, 16'h0100, 4'd1},  // R1 limit reset value
    {3'd3, 6'h08, 16'h0000, 16'h0000, 4'd1},  // R1 status
    {3'd3, 6'h30, 16'h0000, 16'h0000, 4'd1},  // R1 mask
    {3'd0, 6'h04, 16'h0500, 16'h0000, 4'd3},  // R3 limit 5
    {3'd2, 6'h04, 16'h0000, 16'h0500, 4'd3},  // R3
    {3'd3, 6'h08, 16'h0000, 16'h0001, 4'd9},  // R9 running
    {3'd4, 6'h00, 16'd2,    16'h0000, 4'd4},  // R4 two ticks
    {3'd2, 6'h04, 16'h0000, 16'h0500, 4'd3},  // R3 limit read no effect
    {3'd2, 6'h00, 16'h0000, 16'h0300, 4'd4},  // R4 count 3
    {3'd2, 6'h00, 16'h0000, 16'h0500, 4'd5},  // R5 reloaded
    {3'd4, 6'h00, 16'd5,    16'h0000, 4'd6},  // R6 run out
    {3'd3, 6'h08, 16'h0000, 16'h0002, 4'd6},  // R6 expired
    {3'd2, 6'h00, 16'h0000, 16'h0000, 4'd6},  // R6 zero, read does not reload
    {3'd4, 6'h00, 16'd3,    16'h0000, 4'd6},
    {3'd2, 6'h00, 16'h0000, 16'h0000, 4'd5},  // R5 no reload when stopped
    {3'd0, 6'h14, 16'h3412, 16'h0000, 4'd2},  // R2 logical 0x1234
    {3'd2, 6'h14, 16'h0000, 16'h3412, 4'd2},  // R2
    {3'd2, 6'h10, 16'h0000, 16'h3412, 4'd2},  // R2
    {3'd4, 6'h00, 16'd1,    16'h0000, 4'd4},
    {3'd2, 6'h10, 16'h0000, 16'h3312, 4'd4},  // R4 0x1233, kick back to 0x1234
    {3'd4, 6'h00, 16'd1,    16'h0000, 4'd10},
    {3'd3, 6'h10, 16'h0000, 16'h0000, 4'd10}, // R10 byte read of counter
    {3'd2, 6'h10, 16'h0000, 16'h3312, 4'd10}, // R10 no kick happened
    {3'd1, 6'h14, 16'h0077, 16'h0000, 4'd10}, // R10 byte write to limit
    {3'd2, 6'h14, 16'h0000, 16'h3412, 4'd10}, // R10
    {3'd2, 6'h18, 16'h0000, 16'h0000, 4'd10}, // R10 halfword status read
    {3'd0, 6'h30, 16'h0007, 16'h0000, 4'd10}, // R10 halfword mask write
    {3'd3, 6'h30, 16'h0000, 16'h0000, 4'd10}, // R10
    {3'd1, 6'h30, 16'h00FF, 16'h0000, 4'd8},  // R8
    {3'd3, 6'h30, 16'h0000, 16'h0007, 4'd8},  // R8 upper bits zero
    {3'd1, 6'h30, 16'h0000, 16'h0000, 4'd8},
    {3'd3, 6'h34, 16'h0000, 16'h0000, 4'd12}, // R12
    {3'd3, 6'h3C, 16'h0000, 16'h0000, 4'd12}, // R12
    {3'd3, 6'h18, 16'h0000, 16'h0001, 4'd9}   // R9 channel 1 running
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic hw, input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_hw = hw; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic hw, input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_hw = hw; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 pulses", {14'b0, cpu_rst_pulse, sys_rst_pulse}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [5:0]  a;
      logic [15:0] d, e;
      logic [3:0]  t;
      {op, a, d, e, t} = TBL[i];
      case (op)
        3'd0: wr(1'b1, a, d);
        3'd1: wr(1'b0, a, d);
        3'd2: begin rd(1'b1, a, r); chk($sformatf("R%0d vec %0d", t, i), r, e); end
        3'd3: begin rd(1'b0, a, r); chk($sformatf("R%0d vec %0d", t, i), r, e); end
        default: ticks(int'(d));
      endcase
    end

    // R7: channel 0 expired and unmasked -> irq level
    chk("R7 irq level", {15'b0, irq}, 16'h1);
    wr(1'b0, 6'h30, 16'h0001);
    chk("R8 irq masked", {15'b0, irq}, 16'h0);
    wr(1'b0, 6'h30, 16'h0000);

    // R7: channel 2 one-cycle system reset
    wr(1'b1, 6'h24, 16'h0200);
    ticks(1);
    chk("R7 sys early", {15'b0, sys_rst_pulse}, 16'h0);
    ticks(1);
    chk("R7 sys pulse", {15'b0, sys_rst_pulse}, 16'h1);
    chk("R7 no cpu pulse", {15'b0, cpu_rst_pulse}, 16'h0);
    @(negedge clk);
    chk("R7 sys one cycle", {15'b0, sys_rst_pulse}, 16'h0);
    rd(1'b0, 6'h28, r);
    chk("R6 ch2 expired", r, 16'h0002);

    // R8: masked channel 1 expires silently
    wr(1'b0, 6'h30, 16'h0002);
    wr(1'b1, 6'h14, 16'h0100);
    ticks(1);
    chk("R8 cpu suppressed", {15'b0, cpu_rst_pulse}, 16'h0);
    rd(1'b0, 6'h18, r);
    chk("R8 status still expires", r, 16'h0002);
    wr(1'b0, 6'h30, 16'h0000);

    // R7: unmasked channel 1
    wr(1'b1, 6'h14, 16'h0100);
    ticks(1);
    chk("R7 cpu pulse", {15'b0, cpu_rst_pulse}, 16'h1);

    // R11: counter read and tick in the same cycle
    wr(1'b1, 6'h04, 16'h0300);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_hw = 1'b1; bus_addr = 6'h00; tick = 1'b1;
    @(negedge clk);
    bus_req = 1'b0; tick = 1'b0;
    chk("R11 read value", bus_rdata, 16'h0300);
    rd(1'b1, 6'h00, r);
    chk("R11 tick dropped", r, 16'h0300);

    // R6: limit of zero expires on the next tick
    wr(1'b1, 6'h04, 16'h0000);
    rd(1'b0, 6'h08, r);
    chk("R6 zero limit running", r, 16'h0001);
    ticks(1);
    rd(1'b0, 6'h08, r);
    chk("R6 zero limit expires", r, 16'h0002);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 irq after reset", {15'b0, irq}, 16'h0);
    rd(1'b1, 6'h14, r);
    chk("R1 limit after reset", r, 16'h0100);
    rd(1'b0, 6'h08, r);
    chk("R1 status after reset", r, 16'h0000);

    finish_run();
  end
endmodule